// File: doc/BRIEF.md
# Word-Stride Gray Address Codec

This block turns a binary fetch address into a bus address whose sequential steps are cheap to send. A program counter usually moves one instruction word at a time, which is 4 bytes on a 32-bit machine or 8 bytes on a 64-bit machine. Plain binary addresses can flip many bus lines on such a step. Gray-style addresses flip only one line. The block therefore leaves the byte-offset bits below the stride as they are. It applies a reflected Gray mapping to the field above them. As a result, every one-word step changes exactly one bus line.

A companion decoder is built into the same top level. On the memory side it rebuilds the binary address from the coded lines. The stride is a parameter, 4 or 8. The address width is a parameter with a default of 32. A further parameter picks either registered outputs or purely combinational outputs. The code is a pure mapping, so jumps and other non-sequential addresses go through the same conversion and need no special handling.

Top module: `wsg_codec`

## Requirements
- R1: With registered outputs (the default), a high `rst` at a clock edge sets `enc_gray_o` and `dec_bin_o` to all zeros after that edge.
- R2: The offset bits are the lowest log2(STRIDE) bits: bits [1:0] for stride 4 and bits [2:0] for stride 8. They appear on `enc_gray_o` exactly as on `enc_bin_i`, one clock after the input is sampled.
- R3: For each upper bit position i, from log2(STRIDE) up to AW-2, `enc_gray_o[i]` equals `enc_bin_i[i] ^ enc_bin_i[i+1]`. The top bit `enc_gray_o[AW-1]` equals `enc_bin_i[AW-1]`. The result appears one clock after the input is sampled.
- R4: Two input addresses sampled on consecutive cycles may differ by exactly STRIDE, modulo 2^AW. The two resulting codes then differ in exactly one bit. This includes the wrap from the highest word address back to zero, and addresses whose offset bits are not zero.
- R5: The decoder copies the offset bits of `dec_gray_i` unchanged. For each upper position i, `dec_bin_o[i]` is the XOR of `dec_gray_i[j]` for every j from i to AW-1. The result appears one clock after the input is sampled.
- R6: Passing an address through the encoder and then feeding that code into the decoder returns the original address, for every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous reset, active high |
| enc_bin_i | input | AW | Binary address to encode |
| enc_gray_o | output | AW | Coded bus address |
| dec_gray_i | input | AW | Coded bus address to decode |
| dec_bin_o | output | AW | Rebuilt binary address |

## Verification
The assertions take for granted that the default registered build is in use. They also assume that inputs are stable around each rising edge, so that a value sampled at one edge shows up on the outputs at the next. The single-line-change property is checked only when the two sampled addresses differ by exactly one stride. The bench drives every input on the falling edge, so each check compares against an input held steady over a full edge. The stride walks, including the one across the top of the address space, are built by adding the stride to the previous address, which makes sure the single-change precondition really occurs.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // number of byte-offset bits kept outside the Gray field
  function automatic int offset_bits(input int stride);
    return (stride == 8) ? 3 : 2;
  endfunction
endpackage

// File: rtl/wsg_enc.sv
module wsg_enc #(
  parameter int AW  = 32,
  parameter int OFF = 2
) (
  input  logic [AW-1:0] bin_i,
  output logic [AW-1:0] gray_o
);
  localparam int UW = AW - OFF;

  logic [UW-1:0] up_b;
  logic [UW-1:0] up_g;

  assign up_b = bin_i[AW-1:OFF];

  for (genvar i = 0; i < UW; i++) begin : g_bit
    if (i == UW - 1) begin : g_top
      assign up_g[i] = up_b[i];
    end else begin : g_mid
      assign up_g[i] = up_b[i] ^ up_b[i+1];
    end
  end

  assign gray_o = {up_g, bin_i[OFF-1:0]};
endmodule

// File: rtl/wsg_dec.sv
module wsg_dec #(
  parameter int AW  = 32,
  parameter int OFF = 2
) (
  input  logic [AW-1:0] gray_i,
  output logic [AW-1:0] bin_o
);
  localparam int UW = AW - OFF;

  logic [UW-1:0] up_g;
  logic [UW-1:0] up_b;

  assign up_g = gray_i[AW-1:OFF];

  // prefix XOR running from the most significant bit downward
  for (genvar i = UW - 1; i >= 0; i--) begin : g_bit
    if (i == UW - 1) begin : g_top
      assign up_b[i] = up_g[i];
    end else begin : g_mid
      assign up_b[i] = up_b[i+1] ^ up_g[i];
    end
  end

  assign bin_o = {up_b, gray_i[OFF-1:0]};
endmodule

// File: rtl/wsg_stage.sv
module wsg_stage #(
  parameter int  W   = 32,
  parameter bit  REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (rst) q_r <= '0;
      else     q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk ^ rst;
    assign q_o = d_i;
  end
endmodule

// File: rtl/wsg_codec.sv
module wsg_codec #(
  parameter int AW      = 32,
  parameter int STRIDE  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] enc_bin_i,
  output logic [AW-1:0] enc_gray_o,
  input  logic [AW-1:0] dec_gray_i,
  output logic [AW-1:0] dec_bin_o
);
  import wsg_pkg::*;
  localparam int OFF = offset_bits(STRIDE);

  logic [AW-1:0] enc_next;
  logic [AW-1:0] dec_next;

  wsg_enc #(.AW(AW), .OFF(OFF)) enc_i (.bin_i(enc_bin_i), .gray_o(enc_next));
  wsg_dec #(.AW(AW), .OFF(OFF)) dec_i (.gray_i(dec_gray_i), .bin_o(dec_next));

  wsg_stage #(.W(AW), .REG(REG_OUT)) enc_stg_i (
    .clk(clk), .rst(rst), .d_i(enc_next), .q_o(enc_gray_o));
  wsg_stage #(.W(AW), .REG(REG_OUT)) dec_stg_i (
    .clk(clk), .rst(rst), .d_i(dec_next), .q_o(dec_bin_o));
endmodule

// File: rtl/wsg_codec_chk.sv
module wsg_codec_chk #(
  parameter int AW      = 32,
  parameter int STRIDE  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] enc_bin_i,
  input logic [AW-1:0] enc_gray_o,
  input logic [AW-1:0] dec_gray_i,
  input logic [AW-1:0] dec_bin_o
);
  localparam int OFF = wsg_pkg::offset_bits(STRIDE);

  if (REG_OUT) begin : g_chk
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (enc_gray_o == '0 && dec_bin_o == '0)); // R1

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> enc_gray_o[OFF-1:0] == $past(enc_bin_i[OFF-1:0])); // R2

    AST_ENC_MSB: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> enc_gray_o[AW-1] == $past(enc_bin_i[AW-1])); // R3

    AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) &&
       ($past(enc_bin_i) - $past(enc_bin_i, 2) == AW'(STRIDE)))
      |-> $countones(enc_gray_o ^ $past(enc_gray_o)) == 1); // R4

    AST_DEC_OFFSET: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> dec_bin_o[OFF-1:0] == $past(dec_gray_i[OFF-1:0])); // R5

    AST_DEC_MSB: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> dec_bin_o[AW-1] == $past(dec_gray_i[AW-1])); // R5
  end else begin : g_none
    logic unused_ok;
    assign unused_ok = clk ^ rst ^ (^enc_bin_i) ^ (^enc_gray_o) ^
                       (^dec_gray_i) ^ (^dec_bin_o);
  end
endmodule

bind wsg_codec wsg_codec_chk #(.AW(AW), .STRIDE(STRIDE), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .enc_bin_i(enc_bin_i), .enc_gray_o(enc_gray_o),
  .dec_gray_i(dec_gray_i), .dec_bin_o(dec_bin_o));

// File: tb/wsg_codec_tb_top.sv
module wsg_codec_tb_top;
  localparam int AW = 32;
  localparam int STRIDE = 4;
  localparam int NV = 10;

  // {binary, expected code}
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0004, 32'h0000_0004},
    {32'h0000_0008, 32'h0000_000C},
    {32'h0000_000C, 32'h0000_0008},
    {32'h0000_0010, 32'h0000_0018},
    {32'h0000_0013, 32'h0000_001B},
    {32'h0000_0022, 32'h0000_0032},
    {32'h8000_0000, 32'hC000_0000},
    {32'hFFFF_FFFC, 32'h8000_0000},
    {32'hFFFF_FFFF, 32'h8000_0003}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] enc_bin_i = '0;
  logic [AW-1:0] dec_gray_i = '0;
  logic [AW-1:0] enc_gray_o;
  logic [AW-1:0] dec_bin_o;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wsg_codec #(.AW(AW), .STRIDE(STRIDE), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .enc_bin_i(enc_bin_i), .enc_gray_o(enc_gray_o),
    .dec_gray_i(dec_gray_i), .dec_bin_o(dec_bin_o));

  function automatic logic [AW-1:0] model_enc(input logic [AW-1:0] b);
    logic [AW-3:0] u;
    u = b[AW-1:2];
    return {u ^ (u >> 1), b[1:0]};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] b, input logic [AW-1:0] g);
    enc_bin_i  = b;
    dec_gray_i = g;
    @(negedge clk);
    check("R3 encode", enc_gray_o, g);
    check("R5 decode", dec_bin_o, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset enc", enc_gray_o, '0);
    check("R1 reset dec", dec_bin_o, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) apply(VEC[i][63:32], VEC[i][31:0]);

    // R2: offset bits copied, stride-4 field boundary
    enc_bin_i = 32'h0000_0003; @(negedge clk);
    check("R2 offset", {30'd0, enc_gray_o[1:0]}, 32'h3);

    // R4: stride walks, one from zero and one across the top with offset 1
    for (int w = 0; w < 2; w++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] prev;
      a = (w == 0) ? 32'h0 : 32'hFFFF_FFE1;
      enc_bin_i = a; @(negedge clk);
      prev = enc_gray_o;
      for (int k = 0; k < 16; k++) begin
        a = a + STRIDE;
        enc_bin_i = a; @(negedge clk);
        check("R4 one-bit step", 32'($countones(enc_gray_o ^ prev)), 32'd1);
        prev = enc_gray_o;
      end
    end

    // R6: round trip by looping the code back into the decoder
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      a = 32'h9E37_79B9 * k + 32'h1234_5677;
      enc_bin_i = a; @(negedge clk);
      check("R3 model", enc_gray_o, model_enc(a));
      dec_gray_i = enc_gray_o; @(negedge clk);
      check("R6 round trip", dec_bin_o, a);
    end

    // R1: reset in mid run
    enc_bin_i = 32'hDEAD_BEEF; dec_gray_i = 32'h1357_9BDF; @(negedge clk);
    rst = 1'b1; @(negedge clk);
    check("R1 mid reset enc", enc_gray_o, '0);
    check("R1 mid reset dec", dec_bin_o, '0);
    rst = 1'b0; @(negedge clk);
    check("R3 after reset", enc_gray_o, model_enc(32'hDEAD_BEEF));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule